// File: doc/BRIEF.md
# Instruction Decode Control Unit

This block turns a 16-bit instruction word into the steering signals of a small single-cycle 8-bit datapath. It identifies the operation from the 4-bit opcode in the top nibble. For register-format words it also uses the 3-bit function code in the bottom bits. From these it raises the enables for register write-back, memory store, load-data return, immediate operand, conditional branch and unconditional jump. It also gives a 2-bit ALU operation code and a bit that says which instruction field names the destination register.

The decoder also gathers the 6-bit immediate, which the instruction splits into two 3-bit pieces at bits 11:9 and 2:0. It sign-extends this immediate to the data width. It passes on the 7-bit jump target field as well. Every output is captured in one register stage with a synchronous active-high reset, so the surrounding pipeline sees a clean, glitch-free control word one clock after the instruction is presented. Reset loads a bubble with every enable low.

Top module: `ctrl_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, every output becomes zero at that edge: all enables low, `alu_op` = 00, `dst_sel` = 0, `imm` = 0, `jaddr` = 0.
- R2: Opcode (bits 15:12) 0000 with function code (bits 2:0) 000, 010, 100 or 101 sets `reg_wr`, clears the other five enables and `dst_sel`, and sets `alu_op` to 00 (add), 01 (subtract), 10 (AND) or 11 (OR) respectively.
- R3: Opcode 0100 (add immediate) sets `reg_wr` and `alu_src`, clears the other enables, and sets `alu_op` = 00 and `dst_sel` = 1 (destination taken from bits 5:3).
- R4: Opcode 1011 (load) sets `mem_to_reg`, `reg_wr` and `alu_src`, clears `mem_wr`, `branch` and `jump`, and sets `alu_op` = 00 and `dst_sel` = 1.
- R5: Opcode 1111 (store) sets `mem_wr` and `alu_src`, clears `reg_wr`, `mem_to_reg`, `branch` and `jump`, and sets `alu_op` = 00 and `dst_sel` = 1.
- R6: Opcode 1000 (branch if equal) sets `branch` only, with `alu_op` = 01 so that a zero difference means equality, and `dst_sel` = 1.
- R7: Opcode 0010 (jump) sets `jump` only, with `alu_op` = 00 and `dst_sel` = 0.
- R8: Any other opcode, and opcode 0000 with function code 001, 011, 110 or 111, drives all six enables low, `alu_op` = 00 and `dst_sel` = 0.
- R9: `imm` equals the 6-bit value {bits 11:9, bits 2:0} of the instruction, sign-extended from its top bit (bit 11) to 8 bits, for every opcode.
- R10: `jaddr` equals bits 6:0 of the instruction, for every opcode.
- R11: Outputs change only at a rising edge and reflect the instruction present at that edge; a change of `instr` between edges leaves them unchanged.
- R12: At most one of `branch`, `jump`, `mem_wr` and `mem_to_reg` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 16 | Instruction word to decode |
| mem_to_reg | output | 1 | Write-back data comes from data memory |
| mem_wr | output | 1 | Store to data memory |
| reg_wr | output | 1 | Write the destination register |
| alu_src | output | 1 | Second ALU operand is the immediate |
| branch | output | 1 | Conditional branch on equality |
| jump | output | 1 | Unconditional jump |
| alu_op | output | 2 | 00 add, 01 subtract, 10 AND, 11 OR |
| dst_sel | output | 1 | 0: destination in bits 11:9, 1: destination in bits 5:3 |
| imm | output | 8 | Sign-extended split immediate |
| jaddr | output | 7 | Jump target field |

## Verification
The case that uniform random words rarely reach is a register-format opcode whose function code is one of the four unused values. Those words share the opcode of the legal arithmetic operations, and they must fall to a bubble rather than to the nearest legal operation. The stimulus therefore draws most opcodes from the defined set and sweeps every function code under opcode 0000 in a directed pass. It also walks the immediate across its sign boundary, and raises reset while a load is held so that the bubble appears even though the instruction input is still live.

// File: rtl/ctrl_dec_pkg.sv
package ctrl_dec_pkg;

  localparam logic [3:0] OPC_REG  = 4'b0000;
  localparam logic [3:0] OPC_ADDI = 4'b0100;
  localparam logic [3:0] OPC_LOAD = 4'b1011;
  localparam logic [3:0] OPC_STOR = 4'b1111;
  localparam logic [3:0] OPC_BEQ  = 4'b1000;
  localparam logic [3:0] OPC_JMP  = 4'b0010;

  localparam logic [2:0] FN_ADD = 3'b000;
  localparam logic [2:0] FN_SUB = 3'b010;
  localparam logic [2:0] FN_AND = 3'b100;
  localparam logic [2:0] FN_OR  = 3'b101;

  // field positions that the datapath relies on
  localparam int OPC_LSB    = 12;
  localparam int IMM_HI_LSB = 9;
  localparam int IMM_LO_LSB = 0;
  localparam int FN_LSB     = 0;
  localparam int JA_LSB     = 0;

  typedef enum logic [1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_AND = 2'b10,
    ALU_OR  = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic    mem_to_reg;
    logic    mem_wr;
    logic    reg_wr;
    logic    alu_src;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
    logic    dst_sel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/ctrl_opcode_decode.sv
module ctrl_opcode_decode
  import ctrl_dec_pkg::*;
(
  input  logic [3:0] opcode,
  input  logic [2:0] func,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (opcode)
      OPC_REG: begin
        unique case (func)
          FN_ADD:  begin ctrl.reg_wr = 1'b1; ctrl.alu_op = ALU_ADD; end
          FN_SUB:  begin ctrl.reg_wr = 1'b1; ctrl.alu_op = ALU_SUB; end
          FN_AND:  begin ctrl.reg_wr = 1'b1; ctrl.alu_op = ALU_AND; end
          FN_OR:   begin ctrl.reg_wr = 1'b1; ctrl.alu_op = ALU_OR;  end
          default: ctrl = '0;
        endcase
      end
      OPC_ADDI: begin
        ctrl.reg_wr  = 1'b1;
        ctrl.alu_src = 1'b1;
        ctrl.dst_sel = 1'b1;
      end
      OPC_LOAD: begin
        ctrl.mem_to_reg = 1'b1;
        ctrl.reg_wr     = 1'b1;
        ctrl.alu_src    = 1'b1;
        ctrl.dst_sel    = 1'b1;
      end
      OPC_STOR: begin
        ctrl.mem_wr  = 1'b1;
        ctrl.alu_src = 1'b1;
        ctrl.dst_sel = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch  = 1'b1;
        ctrl.alu_op  = ALU_SUB;
        ctrl.dst_sel = 1'b1;
      end
      OPC_JMP: begin
        ctrl.jump = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/ctrl_field_extract.sv
module ctrl_field_extract #(
  parameter int DATA_W  = 8,
  parameter int IMM_W   = 6,
  parameter int JADDR_W = 7
) (
  input  logic [IMM_W/2-1:0]  imm_hi,
  input  logic [IMM_W/2-1:0]  imm_lo,
  input  logic [JADDR_W-1:0]  jfield,
  output logic [DATA_W-1:0]   imm,
  output logic [JADDR_W-1:0]  jaddr
);

  localparam int EXT_W = DATA_W - IMM_W;

  logic [IMM_W-1:0] raw;

  assign raw = {imm_hi, imm_lo};

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm = {{EXT_W{raw[IMM_W-1]}}, raw};
    end else begin : g_trunc
      assign imm = raw[DATA_W-1:0];
    end
  endgenerate

  assign jaddr = jfield;

endmodule

// File: rtl/ctrl_out_stage.sv
module ctrl_out_stage #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/ctrl_decoder.sv
module ctrl_decoder
  import ctrl_dec_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int DATA_W  = 8,
  parameter int IMM_W   = 6,
  parameter int JADDR_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr,
  output logic               mem_to_reg,
  output logic               mem_wr,
  output logic               reg_wr,
  output logic               alu_src,
  output logic               branch,
  output logic               jump,
  output logic [1:0]         alu_op,
  output logic               dst_sel,
  output logic [DATA_W-1:0]  imm,
  output logic [JADDR_W-1:0] jaddr
);

  localparam int HALF_W = IMM_W / 2;
  localparam int WORD_W = CTRL_W + DATA_W + JADDR_W;

  ctrl_t              ctrl_d;
  logic [DATA_W-1:0]  imm_d;
  logic [JADDR_W-1:0] jaddr_d;
  logic [WORD_W-1:0]  word_d;
  logic [WORD_W-1:0]  word_q;
  ctrl_t              ctrl_q;
  logic               unused_fields;

  assign unused_fields = ^instr[8:7];

  ctrl_opcode_decode u_dec (
    .opcode (instr[OPC_LSB +: 4]),
    .func   (instr[FN_LSB +: 3]),
    .ctrl   (ctrl_d)
  );

  ctrl_field_extract #(
    .DATA_W  (DATA_W),
    .IMM_W   (IMM_W),
    .JADDR_W (JADDR_W)
  ) u_fields (
    .imm_hi (instr[IMM_HI_LSB +: HALF_W]),
    .imm_lo (instr[IMM_LO_LSB +: HALF_W]),
    .jfield (instr[JA_LSB +: JADDR_W]),
    .imm    (imm_d),
    .jaddr  (jaddr_d)
  );

  assign word_d = {ctrl_d, imm_d, jaddr_d};

  ctrl_out_stage #(.WIDTH(WORD_W)) u_reg (
    .clk (clk),
    .rst (rst),
    .d   (word_d),
    .q   (word_q)
  );

  assign ctrl_q     = word_q[WORD_W-1 -: CTRL_W];
  assign imm        = word_q[JADDR_W +: DATA_W];
  assign jaddr      = word_q[JADDR_W-1:0];
  assign mem_to_reg = ctrl_q.mem_to_reg;
  assign mem_wr     = ctrl_q.mem_wr;
  assign reg_wr     = ctrl_q.reg_wr;
  assign alu_src    = ctrl_q.alu_src;
  assign branch     = ctrl_q.branch;
  assign jump       = ctrl_q.jump;
  assign alu_op     = ctrl_q.alu_op;
  assign dst_sel    = ctrl_q.dst_sel;

endmodule

// File: rtl/ctrl_decoder_checker.sv
module ctrl_decoder_checker #(
  parameter int INSTR_W = 16,
  parameter int DATA_W  = 8,
  parameter int IMM_W   = 6,
  parameter int JADDR_W = 7
) (
  input logic               clk,
  input logic               rst,
  input logic [INSTR_W-1:0] instr,
  input logic               mem_to_reg,
  input logic               mem_wr,
  input logic               reg_wr,
  input logic               alu_src,
  input logic               branch,
  input logic               jump,
  input logic [1:0]         alu_op,
  input logic               dst_sel,
  input logic [DATA_W-1:0]  imm,
  input logic [JADDR_W-1:0] jaddr
);

  localparam int SIGN_W = DATA_W - IMM_W + 1;

  logic [3:0] opc;
  logic [2:0] fn;
  logic       fn_ok;
  logic       undef;
  logic [5:0] en;

  assign opc   = instr[15:12];
  assign fn    = instr[2:0];
  assign fn_ok = (fn == 3'b000) || (fn == 3'b010) || (fn == 3'b100) || (fn == 3'b101);
  assign undef = (opc == 4'b0000) ? !fn_ok :
                 !(opc == 4'b0100 || opc == 4'b1011 || opc == 4'b1111 ||
                   opc == 4'b1000 || opc == 4'b0010);
  assign en    = {mem_to_reg, mem_wr, reg_wr, alu_src, branch, jump};

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en == 6'b0 && alu_op == 2'b00 && !dst_sel && imm == '0 && jaddr == '0));

  p_regfmt_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opc) == 4'b0000 && $past(fn_ok))
      |-> (en == 6'b001000 && !dst_sel));

  p_addi_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opc) == 4'b0100)
      |-> (en == 6'b001100 && alu_op == 2'b00 && dst_sel));

  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opc) == 4'b1011)
      |-> (en == 6'b101100 && alu_op == 2'b00 && dst_sel));

  p_store_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opc) == 4'b1111)
      |-> (en == 6'b010100 && alu_op == 2'b00 && dst_sel));

  p_beq_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opc) == 4'b1000)
      |-> (en == 6'b000010 && alu_op == 2'b01 && dst_sel));

  p_jump_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opc) == 4'b0010)
      |-> (en == 6'b000001 && alu_op == 2'b00 && !dst_sel));

  p_undef_bubble_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(undef))
      |-> (en == 6'b0 && alu_op == 2'b00 && !dst_sel));

  p_imm_sign_r9: assert property (@(posedge clk) disable iff (rst)
    ($countones(imm[DATA_W-1:IMM_W-1]) == 0) || ($countones(imm[DATA_W-1:IMM_W-1]) == SIGN_W));

  p_jaddr_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (jaddr == $past(instr[JADDR_W-1:0])));

  p_latency_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr[11:9]) != 3'b000 && $past(instr[2:0]) == instr[2:0])
      |-> (imm[IMM_W-1 -: 3] == $past(instr[11:9])));

  p_exclusive_r12: assert property (@(posedge clk) disable iff (rst)
    $countones({branch, jump, mem_wr, mem_to_reg}) <= 1);

endmodule

bind ctrl_decoder ctrl_decoder_checker #(
  .INSTR_W (INSTR_W),
  .DATA_W  (DATA_W),
  .IMM_W   (IMM_W),
  .JADDR_W (JADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .instr      (instr),
  .mem_to_reg (mem_to_reg),
  .mem_wr     (mem_wr),
  .reg_wr     (reg_wr),
  .alu_src    (alu_src),
  .branch     (branch),
  .jump       (jump),
  .alu_op     (alu_op),
  .dst_sel    (dst_sel),
  .imm        (imm),
  .jaddr      (jaddr)
);

// File: tb/ctrl_decoder_test.sv
module ctrl_decoder_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr = 16'h0000;
  logic        mem_to_reg, mem_wr, reg_wr, alu_src, branch, jump, dst_sel;
  logic [1:0]  alu_op;
  logic [7:0]  imm;
  logic [6:0]  jaddr;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  ctrl_decoder uut (
    .clk(clk), .rst(rst), .instr(instr),
    .mem_to_reg(mem_to_reg), .mem_wr(mem_wr), .reg_wr(reg_wr),
    .alu_src(alu_src), .branch(branch), .jump(jump),
    .alu_op(alu_op), .dst_sel(dst_sel), .imm(imm), .jaddr(jaddr)
  );

  // {m2r, mw, rw, as, br, jp, alu_op[1:0], dst_sel}
  function automatic logic [8:0] exp_ctrl(input logic [15:0] w);
    logic [5:0] en = 6'b0;
    logic [1:0] op = 2'b00;
    logic       ds = 1'b0;
    case (w[15:12])
      4'b0000: case (w[2:0])
        3'b000: en = 6'b001000;
        3'b010: begin en = 6'b001000; op = 2'b01; end
        3'b100: begin en = 6'b001000; op = 2'b10; end
        3'b101: begin en = 6'b001000; op = 2'b11; end
        default: ;
      endcase
      4'b0100: begin en = 6'b001100; ds = 1'b1; end
      4'b1011: begin en = 6'b101100; ds = 1'b1; end
      4'b1111: begin en = 6'b010100; ds = 1'b1; end
      4'b1000: begin en = 6'b000010; op = 2'b01; ds = 1'b1; end
      4'b0010: en = 6'b000001;
      default: ;
    endcase
    return {en, op, ds};
  endfunction

  function automatic logic [7:0] exp_imm(input logic [15:0] w);
    return {{2{w[11]}}, w[11:9], w[2:0]};
  endfunction

  function automatic string req_of(input logic [15:0] w);
    case (w[15:12])
      4'b0000: return (w[2:0] inside {3'b000, 3'b010, 3'b100, 3'b101}) ? "R2" : "R8";
      4'b0100: return "R3";
      4'b1011: return "R4";
      4'b1111: return "R5";
      4'b1000: return "R6";
      4'b0010: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [8:0] act_ctrl();
    return {mem_to_reg, mem_wr, reg_wr, alu_src, branch, jump, alu_op, dst_sel};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] w);
    @(negedge clk) instr = w;
    @(negedge clk);
    check(req_of(w), 32'(act_ctrl()), 32'(exp_ctrl(w)));
    check("R9", 32'(imm), 32'(exp_imm(w)));
    check("R10", 32'(jaddr), 32'(w[6:0]));
    check("R12", 32'($countones({branch, jump, mem_wr, mem_to_reg}) <= 1), 32'd1);
  endtask

  function automatic logic [3:0] pick_opc(input int sel);
    case (sel)
      0: return 4'b0000;
      1: return 4'b0100;
      2: return 4'b1011;
      3: return 4'b1111;
      4: return 4'b1000;
      default: return 4'b0010;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd5150));
    repeat (2) @(negedge clk);
    // R1: reset state
    check("R1", 32'({act_ctrl(), imm, jaddr}), 32'd0);
    rst = 1'b0;

    // R2 / R8: every function code under the register opcode
    for (int f = 0; f < 8; f++) apply({4'b0000, 3'b011, 3'b001, 3'b010, 3'(f)});

    // R3..R7 directed
    apply(16'h4A5B);
    apply(16'hB2C1);
    apply(16'hF1FF);
    apply(16'h8E47);
    apply(16'h207F);
    apply(16'h2000);

    // R9: immediate sign boundaries
    apply({4'b0100, 3'b011, 6'b000000, 3'b111});
    apply({4'b0100, 3'b100, 6'b111111, 3'b000});
    apply({4'b1011, 3'b111, 6'b000000, 3'b111});

    // R8: undefined opcodes
    for (int o = 0; o < 16; o++)
      if (!(o inside {0, 4, 11, 15, 8, 2})) apply({4'(o), 12'hFFF});

    // R11: mid-cycle change has no effect before the edge
    apply(16'hB000);
    #1 instr = 16'h2155;
    #1 check("R11", 32'({act_ctrl(), imm, jaddr}), 32'({exp_ctrl(16'hB000), 8'h00, 7'h00}));
    @(negedge clk);
    check("R11", 32'({act_ctrl(), imm, jaddr}), 32'({exp_ctrl(16'h2155), exp_imm(16'h2155), 7'h55}));

    // R1: reset while a load is held on the input
    @(negedge clk) instr = 16'hBFFF; rst = 1'b1;
    @(negedge clk);
    check("R1", 32'({act_ctrl(), imm, jaddr}), 32'd0);
    rst = 1'b0;

    // random mix, biased toward defined opcodes
    for (int i = 0; i < 400; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if (($urandom % 4) != 0) w[15:12] = pick_opc(int'($urandom % 6));
      apply(w);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule